// File: doc/BRIEF.md
# Dual I/O Serial Flash Read Responder

This block is the device side of a serial flash read path. It watches an active-low chip select, a serial clock and two data lines. When the host selects it and sends the dual fast-read opcode, the block takes a byte address and a dummy byte at two bits per clock. It then takes over both lines and streams bytes from a small internal array, two bits per clock, until chip select goes high. Any other opcode makes it stay silent for the rest of the selection.

The pins are oversampled by a fast system clock through a short synchronizer. Serial clock edges are found in that clock domain. Each data line has a value and an output-enable, and the tri-state buffer belongs to the chip's pad ring. The array is a register array of `2**ADDR_W` bytes. Reset loads it with a fixed computed pattern, so read data can be predicted without a write path.

Top module: `spi_dual_rd_resp`

## Requirements
- R1: After reset, and whenever chip select is high, both output-enables are 0.
- R2: The opcode is 8 bits, most significant first, taken from line 0 only on 8 rising serial-clock edges. The value 0xBB starts a read. Line 1 is ignored during the opcode.
- R3: Any opcode other than 0xBB leaves both output-enables at 0 until chip select rises. The next selection decodes a fresh opcode.
- R4: The address takes 12 rising edges. Each edge carries one bit pair: line 1 holds the odd bit (A23, A21 … A1) and line 0 the even bit (A22 … A0), with the highest pair first. Only the low `ADDR_W` address bits select the byte; the upper bits are ignored.
- R5: Four rising edges of dummy follow the address. The values on both lines during the dummy edges do not affect the data.
- R6: Both output-enables go to 1 at the first falling edge after the fourth dummy rising edge. They stay at 1 until chip select rises, and they are 0 before that falling edge.
- R7: Each byte takes 4 clocks. Line 1 carries D7, D5, D3, D1 and line 0 carries D6, D4, D2, D0, with the highest pair first. After reset, byte i of the array holds (i*37 + 0x5A) mod 256.
- R8: Bytes stream without a gap from consecutive indices. After index `2**ADDR_W-1`, the stream continues at index 0.
- R9: Both serial-clock modes work. The clock may idle low (mode 0) or high (mode 3) while chip select is high.
- R10: A rise of chip select at any point ends the transfer. Both output-enables drop, and no partial opcode, address or byte carries into the next selection.
- R11: The output pair changes only after a falling serial-clock edge and is steady through the following high phase. With a half-period of at least 6 system clocks, it is valid at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sio_in | input | 2 | Values seen on data lines 1 and 0 |
| sio_out | output | 2 | Values driven on data lines 1 and 0 |
| sio_oe | output | 2 | Output-enables for data lines 1 and 0 |

## Verification
A wrong phase counter moves the turnaround point. The enables then rise during the address or dummy, or the first byte comes out shifted by whole bit pairs; either shows at the first rising edge where it happens. A bad index register shows as a wrong byte at the first byte boundary, or at the wrap from the top index. State left over after an abort corrupts the opcode or address of the next selection, so its first byte comes out wrong or never appears. A drive window that is too wide shows as an enable sampled high while chip select is high, or after a rejected opcode.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_e;

  localparam logic [7:0] DUAL_READ_OP = 8'hBB;
  localparam int         ADDR_BITS    = 24;
  localparam int         CMD_CLKS     = 8;
  localparam int         ADDR_CLKS    = ADDR_BITS / 2;
  localparam int         DUMMY_CLKS   = 4;
  localparam int         CNT_W        = 4;

  function automatic logic [7:0] fill_byte(input int unsigned idx);
    return 8'((idx * 37 + 32'h5A) % 256);
  endfunction

endpackage

// File: rtl/spi_dual_sync.sv
module spi_dual_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_r [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_r[k] <= RST_VAL;
    end else begin
      stage_r[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_r[k] <= stage_r[k-1];
    end
  end

  assign q = stage_r[STAGES-1];

endmodule

// File: rtl/spi_dual_mem.sv
module spi_dual_mem
  import spi_dual_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= fill_byte(i);
    end
  end

  assign rd_data = cells[rd_idx];

endmodule

// File: rtl/spi_dual_fsm.sv
module spi_dual_fsm
  import spi_dual_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [1:0]        din,
  output logic [ADDR_W-1:0] rd_idx,
  input  logic [7:0]        rd_data,
  output logic [1:0]        sio_out,
  output logic [1:0]        sio_oe,
  output logic              in_data,
  output logic              skipping
);

  localparam logic [CNT_W-1:0] LAST_CMD   = CNT_W'(CMD_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);

  phase_e               phase;
  logic [CNT_W-1:0]     cnt;
  logic [7:0]           op_sh;
  logic [ADDR_BITS-1:0] addr_sh;
  logic [1:0]           pair;
  logic [7:0]           dsh;
  logic [7:0]           op_next;

  assign op_next = {op_sh[6:0], din[0]};

  always_ff @(posedge clk) begin
    if (rst || cs_hi) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      op_sh   <= '0;
      addr_sh <= '0;
      pair    <= '0;
      dsh     <= '0;
      sio_out <= '0;
      sio_oe  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_CMD;
          cnt   <= '0;
        end
        PH_CMD: if (sck_rise) begin
          op_sh <= op_next;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST_CMD) begin
            cnt   <= '0;
            phase <= (op_next == DUAL_READ_OP) ? PH_ADDR : PH_SKIP;
          end
        end
        PH_ADDR: if (sck_rise) begin
          addr_sh <= {addr_sh[ADDR_BITS-3:0], din[1], din[0]};
          cnt     <= cnt + 1'b1;
          if (cnt == LAST_ADDR) begin
            cnt   <= '0;
            phase <= PH_DUMMY;
          end
        end
        PH_DUMMY: if (sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_DUMMY) begin
            cnt   <= '0;
            pair  <= '0;
            phase <= PH_DATA;
          end
        end
        PH_DATA: if (sck_fall) begin
          sio_oe <= 2'b11;
          pair   <= pair + 1'b1;
          if (pair == 2'd0) begin
            sio_out                 <= rd_data[7:6];
            dsh                     <= {rd_data[5:0], 2'b00};
            addr_sh[ADDR_W-1:0]     <= addr_sh[ADDR_W-1:0] + 1'b1;
          end else begin
            sio_out <= dsh[7:6];
            dsh     <= {dsh[5:0], 2'b00};
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_idx   = addr_sh[ADDR_W-1:0];
  assign in_data  = (phase == PH_DATA);
  assign skipping = (phase == PH_SKIP);

endmodule

// File: rtl/spi_dual_rd_resp.sv
module spi_dual_rd_resp #(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [1:0] sio_in,
  output logic [1:0] sio_out,
  output logic [1:0] sio_oe
);

  logic [3:0]        pins_s;
  logic              cs_hi;
  logic              sck_s;
  logic              sck_q;
  logic              sck_rise;
  logic              sck_fall;
  logic [1:0]        din_s;
  logic [ADDR_W-1:0] rd_idx;
  logic [7:0]        rd_data;
  logic              in_data;
  logic              skipping;

  spi_dual_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1000)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, sio_in}),
    .q   (pins_s)
  );

  assign cs_hi = pins_s[3];
  assign sck_s = pins_s[2];
  assign din_s = pins_s[1:0];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  spi_dual_fsm #(
    .ADDR_W (ADDR_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cs_hi    (cs_hi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .din      (din_s),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .sio_out  (sio_out),
    .sio_oe   (sio_oe),
    .in_data  (in_data),
    .skipping (skipping)
  );

  spi_dual_mem #(
    .ADDR_W (ADDR_W)
  ) u_mem (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/spi_dual_rd_resp_chk.sv
module spi_dual_rd_resp_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_hi,
  input logic       sck_fall,
  input logic       in_data,
  input logic       skipping,
  input logic [1:0] sio_out,
  input logic [1:0] sio_oe
);

  // R6: enables only inside the data phase
  a_r6_oe_only_in_data: assert property (@(posedge clk) disable iff (rst)
    (sio_oe != 2'b00) |-> in_data);

  // R6: both lines are enabled together
  a_r6_oe_pair: assert property (@(posedge clk) disable iff (rst)
    (sio_oe == 2'b00) || (sio_oe == 2'b11));

  // R10 / R1: deselect releases both lines on the next cycle
  a_r10_cs_releases: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (sio_oe == 2'b00));

  // R3: a rejected opcode never drives
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
    skipping |-> (sio_oe == 2'b00));

  // R11: output pair moves only after a falling edge
  a_r11_out_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !cs_hi) |=> $stable(sio_out));

endmodule

bind spi_dual_rd_resp spi_dual_rd_resp_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_hi    (cs_hi),
  .sck_fall (sck_fall),
  .in_data  (in_data),
  .skipping (skipping),
  .sio_out  (sio_out),
  .sio_oe   (sio_oe)
);

// File: tb/spi_dual_rd_resp_tb.sv
module spi_dual_rd_resp_tb;

  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int H      = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       host_oe = 1'b0;
  logic [1:0] host_d = 2'b00;
  logic [1:0] sio_out;
  logic [1:0] sio_oe;
  logic [1:0] bus;

  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] exp_q [$];
  logic [7:0] got_byte;
  string      cur_tag = "R7";
  event       byte_ev;

  always #2 clk = ~clk;

  assign bus[1] = sio_oe[1] ? sio_out[1] : (host_oe & host_d[1]);
  assign bus[0] = sio_oe[0] ? sio_out[0] : (host_oe & host_d[0]);

  spi_dual_rd_resp #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sck     (sck),
    .sio_in  (bus),
    .sio_out (sio_out),
    .sio_oe  (sio_oe)
  );

  function automatic logic [7:0] model(input int unsigned i);
    return 8'((i * 37 + 90) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input bit mode3);
    sck  = mode3;
    wait_clk(H);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic finish(input bit mode3);
    if (!mode3) begin
      sck = 1'b0;
      wait_clk(H);
    end
    cs_n    = 1'b1;
    host_oe = 1'b0;
    wait_clk(2 * H);
    chk(sio_oe == 2'b00, "R10 oe after deselect", sio_oe, 0);
  endtask

  // one input clock; checks that the responder is not driving (R6)
  task automatic in_clk(input logic [1:0] d);
    sck     = 1'b0;
    host_d  = d;
    host_oe = 1'b1;
    wait_clk(H);
    chk(sio_oe == 2'b00, "R6 no drive before data", sio_oe, 0);
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic send_cmd(input logic [7:0] op, input int nbits);
    // line 1 carries the inverse to show it is ignored (R2)
    for (int i = 7; i > 7 - nbits; i--) in_clk({~op[i], op[i]});
  endtask

  task automatic send_addr(input logic [23:0] a, input int npairs);
    for (int k = 11; k > 11 - npairs; k--) in_clk({a[2*k+1], a[2*k]});
  endtask

  task automatic send_dummy();
    // arbitrary dummy values (R5)
    in_clk(2'b10);
    in_clk(2'b01);
    in_clk(2'b11);
    in_clk(2'b10);
    host_oe = 1'b0;
  endtask

  task automatic data_clk(output logic [1:0] pr);
    logic [1:0] late;
    sck = 1'b0;
    wait_clk(H);
    pr = bus;
    chk(sio_oe == 2'b11, "R6 drive in data", sio_oe, 3);
    sck = 1'b1;
    wait_clk(H);
    late = bus;
    chk(late == pr, "R11 steady through high", late, pr);
  endtask

  task automatic read_bytes(input int n);
    logic [1:0] pr;
    for (int b = 0; b < n; b++) begin
      logic [7:0] acc;
      acc = '0;
      for (int p = 0; p < 4; p++) begin
        data_clk(pr);
        acc = {acc[5:0], pr};
      end
      got_byte = acc;
      -> byte_ev;
      wait_clk(1);
    end
  endtask

  task automatic read_txn(input logic [23:0] a, input int n, input bit mode3, input string tag);
    cur_tag = tag;
    for (int j = 0; j < n; j++) exp_q.push_back(model((a + j) % DEPTH));
    start(mode3);
    send_cmd(8'hBB, 8);
    send_addr(a, 12);
    send_dummy();
    read_bytes(n);
    finish(mode3);
  endtask

  // monitor: pops expected bytes as the driver assembles them
  always begin
    @(byte_ev);
    if (exp_q.size() == 0) begin
      chk(1'b0, {cur_tag, " unexpected byte"}, got_byte, 0);
    end else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(got_byte == e, cur_tag, got_byte, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    chk(sio_oe == 2'b00, "R1 reset oe", sio_oe, 0);

    // R2 R4 R7: plain read, mode 0
    read_txn(24'h000005, 4, 1'b0, "R4/R7 mode0 read");
    // R8 R9: wrap from the top index, mode 3
    read_txn(24'h00003D, 5, 1'b1, "R8/R9 wrap mode3");
    // R4: upper address bits ignored
    read_txn(24'hABCD41, 3, 1'b1, "R4 upper bits ignored");

    // R3: rejected opcode stays silent
    start(1'b0);
    send_cmd(8'h3B, 8);
    host_oe = 1'b0;
    for (int i = 0; i < 28; i++) begin
      sck = 1'b0;
      wait_clk(H);
      chk(sio_oe == 2'b00, "R3 silent after bad opcode", sio_oe, 0);
      sck = 1'b1;
      wait_clk(H);
    end
    finish(1'b0);
    read_txn(24'h000020, 2, 1'b0, "R3 read after bad opcode");

    // R10: abort inside a data byte
    cur_tag = "R10 before abort";
    exp_q.push_back(model(16));
    start(1'b0);
    send_cmd(8'hBB, 8);
    send_addr(24'h000010, 12);
    send_dummy();
    read_bytes(1);
    begin
      logic [1:0] pr;
      data_clk(pr);
      data_clk(pr);
    end
    finish(1'b0);
    read_txn(24'h000030, 2, 1'b0, "R10 clean after data abort");

    // R10: abort inside the address
    start(1'b1);
    send_cmd(8'hBB, 8);
    send_addr(24'hFFFFFF, 5);
    finish(1'b1);
    read_txn(24'h000007, 2, 1'b1, "R10 clean after address abort");

    // R10: abort inside the opcode
    start(1'b0);
    send_cmd(8'hBB, 4);
    finish(1'b0);
    read_txn(24'h00003F, 2, 1'b0, "R10/R8 clean after opcode abort");

    chk(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule